// File: doc/BRIEF.md
# L2 Cache Bus Operation Responder

This block decides, for every bus operation presented to a write-back second-level cache controller, what the cache must do about it. The operation arrives on one cycle with its class (ordinary processor access, first-level copy-back, second-level cast-out, or snoop caused by a PCI-to-memory transfer). It also carries its sideband bits: burst or single beat, read or write, the address decode, tag hit and dirty status, write-through, cache-inhibit, global, retry, and the snoop-disable and partial-update controls.

One clock later the block presents a set of registered response flags. These say whether the cache drives the data, writes or allocates the line, invalidates it, casts out a dirty victim, or takes no part at all. Tag and data arrays are outside the block. The controller around it uses the flags to sequence the array accesses.

Top module: `l2_bus_resp`

## Requirements
- R1: An operation with `sys_mem_i`=0 (PCI address space) gives `ignore_o`=1 and every other flag 0, whatever its other inputs.
- R2: A snoop (`op_class_i`=2'b11) gives `ignore_o`=1 and no other flag when `snoop_dis_i`=1. A snoop with `gbl_i`=0 gives all flags 0.
- R3: An ordinary access (`op_class_i`=2'b00) that reads and hits gives `supply_o`=1 for both single-beat and burst transfers. A single-beat read miss gives no flag.
- R4: A read snoop hit gives `supply_o`. A write snoop hit to a dirty line gives `supply_o` and `inval_o`. A write snoop hit to a clean line gives `inval_o` only. Snoops never give `update_o`.
- R5: An ordinary burst read miss gives `update_o`. If the victim is dirty (`dirty_i`=1) it also gives `castout_o`.
- R6: An ordinary burst write gives `update_o` on a hit, and on a miss unless `wt_i`=1. A first-level copy-back (`op_class_i`=2'b01) always gives `update_o`, whether it is a burst or not.
- R7: An ordinary single-beat write hit gives `update_o` only when `part_upd_i`=1. A single-beat write miss never gives it.
- R8: A retried operation (`artry_i`=1) gives no supply, update, invalidate or cast-out.
- R9: A cache-inhibited operation (`ci_i`=1) never gives `update_o` or `castout_o`. A read hit is still supplied.
- R10: A second-level cast-out operation (`op_class_i`=2'b10) gives `supply_o` only.
- R11: Flags and `resp_valid_o` appear on the clock edge after the operation is sampled with `op_valid_i`=1. They are all 0 while idle and while `rst_ni` is low, and reset clears them at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_class_i | input | 2 | 00 ordinary, 01 L1 copy-back, 10 L2 cast-out, 11 snoop |
| burst_i | input | 1 | Burst transfer (0 = single beat) |
| write_i | input | 1 | Write (0 = read) |
| sys_mem_i | input | 1 | Address decodes to system memory (0 = PCI space) |
| hit_i | input | 1 | Tag hit |
| dirty_i | input | 1 | Addressed or victim line is modified |
| wt_i | input | 1 | Write-through attribute |
| ci_i | input | 1 | Cache-inhibit attribute |
| gbl_i | input | 1 | Global (coherent) attribute |
| artry_i | input | 1 | Address retry |
| snoop_dis_i | input | 1 | Snooping disabled |
| part_upd_i | input | 1 | Partial line update on single-beat write hits |
| resp_valid_o | output | 1 | Response flags valid |
| ignore_o | output | 1 | Cache takes no part |
| supply_o | output | 1 | Cache drives the data |
| update_o | output | 1 | Write or allocate the line |
| inval_o | output | 1 | Invalidate the line |
| castout_o | output | 1 | Dirty victim must be written back |

## Verification
A wrong rule in the decision logic shows as a wrong flag on the cycle right after the operation, so each operation pattern is checked exactly one clock after it is presented. Back-to-back operations are applied, so stale or sticky state would carry into the next response. It would show there as a flag the following pattern should not raise. The retry, inhibit, address-space and snoop-disable overrides are each paired with an input pattern that would otherwise raise a flag, which makes a lost override visible at once.

// File: rtl/l2_resp_pkg.sv
package l2_resp_pkg;
  localparam int unsigned N_CLASS = 4;
  localparam int unsigned CLS_W   = $clog2(N_CLASS);

  typedef enum logic [CLS_W-1:0] {
    OP_NORMAL  = 2'b00,
    OP_L1_CPBK = 2'b01,
    OP_L2_CAST = 2'b10,
    OP_SNOOP   = 2'b11
  } op_class_e;

  typedef struct packed {
    op_class_e  cls;
    logic       burst;
    logic       write;
    logic       sys_mem;
    logic       hit;
    logic       dirty;
    logic       wt;
    logic       ci;
    logic       gbl;
    logic       artry;
  } op_t;

  typedef struct packed {
    logic ignore;
    logic supply;
    logic update;
    logic inval;
    logic castout;
  } resp_t;
endpackage

// File: rtl/l2_op_qualify.sv
module l2_op_qualify
  import l2_resp_pkg::*;
(
  input  logic               valid_i,
  input  op_t                op_i,
  input  logic               snoop_dis_i,
  output logic               ignore_o,
  output logic               act_o,
  output logic [N_CLASS-1:0] cls_oh_o
);
  logic snoop_off;

  assign snoop_off = (op_i.cls == OP_SNOOP) && snoop_dis_i;
  assign ignore_o  = valid_i && (!op_i.sys_mem || snoop_off);
  // retried operations are accepted but take no action
  assign act_o     = valid_i && !ignore_o && !op_i.artry;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_cls
    assign cls_oh_o[c] = (op_i.cls == op_class_e'(c));
  end
endmodule

// File: rtl/l2_supply_rules.sv
module l2_supply_rules
  import l2_resp_pkg::*;
(
  input  logic               act_i,
  input  logic [N_CLASS-1:0] cls_oh_i,
  input  op_t                op_i,
  output logic               supply_o,
  output logic               inval_o
);
  logic norm_rd_hit, cast_op, snp, snp_rd_hit, snp_wr_hit;

  assign norm_rd_hit = cls_oh_i[OP_NORMAL] && !op_i.write && op_i.hit;
  assign cast_op     = cls_oh_i[OP_L2_CAST];
  assign snp         = cls_oh_i[OP_SNOOP] && op_i.gbl;
  assign snp_rd_hit  = snp && !op_i.write && op_i.hit;
  assign snp_wr_hit  = snp && op_i.write && op_i.hit;

  assign supply_o = act_i && (norm_rd_hit || cast_op || snp_rd_hit ||
                              (snp_wr_hit && op_i.dirty));
  assign inval_o  = act_i && snp_wr_hit;
endmodule

// File: rtl/l2_update_rules.sv
module l2_update_rules
  import l2_resp_pkg::*;
(
  input  logic               act_i,
  input  logic [N_CLASS-1:0] cls_oh_i,
  input  op_t                op_i,
  input  logic               part_upd_i,
  output logic               update_o,
  output logic               castout_o
);
  logic norm, rd_alloc, bw_upd, sw_upd, cpbk_upd, allow;

  assign allow    = act_i && !op_i.ci;
  assign norm     = cls_oh_i[OP_NORMAL];
  assign rd_alloc = norm && !op_i.write && op_i.burst && !op_i.hit;
  // write-through burst misses do not allocate
  assign bw_upd   = norm && op_i.write && op_i.burst && (op_i.hit || !op_i.wt);
  assign sw_upd   = norm && op_i.write && !op_i.burst && op_i.hit && part_upd_i;
  assign cpbk_upd = cls_oh_i[OP_L1_CPBK];

  assign update_o  = allow && (rd_alloc || bw_upd || sw_upd || cpbk_upd);
  assign castout_o = allow && rd_alloc && op_i.dirty;
endmodule

// File: rtl/l2_bus_resp.sv
module l2_bus_resp
  import l2_resp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [CLS_W-1:0] op_class_i,
  input  logic             burst_i,
  input  logic             write_i,
  input  logic             sys_mem_i,
  input  logic             hit_i,
  input  logic             dirty_i,
  input  logic             wt_i,
  input  logic             ci_i,
  input  logic             gbl_i,
  input  logic             artry_i,
  input  logic             snoop_dis_i,
  input  logic             part_upd_i,
  output logic             resp_valid_o,
  output logic             ignore_o,
  output logic             supply_o,
  output logic             update_o,
  output logic             inval_o,
  output logic             castout_o
);
  op_t                op;
  resp_t              nxt, q;
  logic               act;
  logic [N_CLASS-1:0] cls_oh;
  logic               vld_q;

  assign op = '{cls: op_class_e'(op_class_i), burst: burst_i, write: write_i,
                sys_mem: sys_mem_i, hit: hit_i, dirty: dirty_i, wt: wt_i,
                ci: ci_i, gbl: gbl_i, artry: artry_i};

  l2_op_qualify i_qual (
    .valid_i     (op_valid_i),
    .op_i        (op),
    .snoop_dis_i (snoop_dis_i),
    .ignore_o    (nxt.ignore),
    .act_o       (act),
    .cls_oh_o    (cls_oh)
  );

  l2_supply_rules i_sup (
    .act_i    (act),
    .cls_oh_i (cls_oh),
    .op_i     (op),
    .supply_o (nxt.supply),
    .inval_o  (nxt.inval)
  );

  l2_update_rules i_upd (
    .act_i      (act),
    .cls_oh_i   (cls_oh),
    .op_i       (op),
    .part_upd_i (part_upd_i),
    .update_o   (nxt.update),
    .castout_o  (nxt.castout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      q     <= '0;
    end else begin
      vld_q <= op_valid_i;
      q     <= nxt;
    end
  end

  assign resp_valid_o = vld_q;
  assign ignore_o     = q.ignore;
  assign supply_o     = q.supply;
  assign update_o     = q.update;
  assign inval_o      = q.inval;
  assign castout_o    = q.castout;
endmodule

// File: rtl/l2_bus_resp_chk.sv
module l2_bus_resp_chk
  import l2_resp_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [CLS_W-1:0] op_class_i,
  input logic             sys_mem_i,
  input logic             ci_i,
  input logic             artry_i,
  input logic             snoop_dis_i,
  input logic             resp_valid_o,
  input logic             ignore_o,
  input logic             supply_o,
  input logic             update_o,
  input logic             inval_o,
  input logic             castout_o
);
  assert_pci_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && $past(op_valid_i && !sys_mem_i)) |->
      (ignore_o && !supply_o && !update_o && !inval_o && !castout_o));

  assert_snoop_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && $past(op_valid_i && op_class_i == OP_SNOOP && snoop_dis_i)) |->
      (ignore_o && !supply_o && !inval_o));

  assert_snoop_no_update_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && $past(op_valid_i && op_class_i == OP_SNOOP)) |-> !update_o);

  assert_castout_needs_alloc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    castout_o |-> (update_o && !supply_o && !inval_o));

  assert_retry_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && $past(op_valid_i && artry_i)) |->
      (!supply_o && !update_o && !inval_o && !castout_o));

  assert_inhibit_no_alloc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && $past(op_valid_i && ci_i)) |-> (!update_o && !castout_o));

  assert_cast_op_supply_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && $past(op_valid_i && sys_mem_i && !artry_i &&
                           op_class_i == OP_L2_CAST)) |->
      (supply_o && !update_o && !inval_o));

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !(ignore_o || supply_o || update_o || inval_o || castout_o));

  assert_resp_from_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(op_valid_i));

  assert_one_role_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(supply_o && update_o));
endmodule

bind l2_bus_resp l2_bus_resp_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .op_valid_i   (op_valid_i),
  .op_class_i   (op_class_i),
  .sys_mem_i    (sys_mem_i),
  .ci_i         (ci_i),
  .artry_i      (artry_i),
  .snoop_dis_i  (snoop_dis_i),
  .resp_valid_o (resp_valid_o),
  .ignore_o     (ignore_o),
  .supply_o     (supply_o),
  .update_o     (update_o),
  .inval_o      (inval_o),
  .castout_o    (castout_o)
);

// File: tb/test_l2_bus_resp.sv
`timescale 1ns/1ps
module test_l2_bus_resp;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic op_valid, burst, write, sys_mem, hit, dirty, wt, ci, gbl, artry, sdis, pu;
  logic [1:0] cls;
  logic resp_valid, ign, sup, upd, inv, co;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  l2_bus_resp i_l2_bus_resp (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid), .op_class_i(cls),
    .burst_i(burst), .write_i(write), .sys_mem_i(sys_mem), .hit_i(hit),
    .dirty_i(dirty), .wt_i(wt), .ci_i(ci), .gbl_i(gbl), .artry_i(artry),
    .snoop_dis_i(sdis), .part_upd_i(pu), .resp_valid_o(resp_valid),
    .ignore_o(ign), .supply_o(sup), .update_o(upd), .inval_o(inv),
    .castout_o(co)
  );

  // {req, class, burst write sys hit dirty wt ci gbl artry sdis pu, ign sup upd inv co}
  localparam int NV = 29;
  localparam logic [21:0] VECS [NV] = '{
    {4'd3,  2'b00, 11'b00110001000, 5'b01000}, // R3 single read hit
    {4'd3,  2'b00, 11'b10111001000, 5'b01000}, // R3 burst read hit
    {4'd5,  2'b00, 11'b10100001000, 5'b00100}, // R5 burst read miss clean
    {4'd5,  2'b00, 11'b10101001000, 5'b00101}, // R5 burst read miss dirty
    {4'd3,  2'b00, 11'b00100001000, 5'b00000}, // R3 single read miss
    {4'd6,  2'b00, 11'b11110001000, 5'b00100}, // R6 burst write hit
    {4'd6,  2'b00, 11'b11100001000, 5'b00100}, // R6 burst write miss
    {4'd6,  2'b00, 11'b11100101000, 5'b00000}, // R6 burst write miss wt
    {4'd7,  2'b00, 11'b01110001000, 5'b00000}, // R7 single write hit, pu off
    {4'd7,  2'b00, 11'b01110001001, 5'b00100}, // R7 single write hit, pu on
    {4'd7,  2'b00, 11'b01100001001, 5'b00000}, // R7 single write miss
    {4'd6,  2'b01, 11'b01100001000, 5'b00100}, // R6 copy-back single miss
    {4'd10, 2'b10, 11'b10111001000, 5'b01000}, // R10 cast-out op
    {4'd4,  2'b11, 11'b00110001000, 5'b01000}, // R4 snoop read hit
    {4'd4,  2'b11, 11'b01111001000, 5'b01010}, // R4 snoop write hit dirty
    {4'd4,  2'b11, 11'b01110001000, 5'b00010}, // R4 snoop write hit clean
    {4'd4,  2'b11, 11'b00100001000, 5'b00000}, // R4 snoop read miss
    {4'd2,  2'b11, 11'b00110001010, 5'b10000}, // R2 snoop disabled
    {4'd2,  2'b11, 11'b00110000000, 5'b00000}, // R2 snoop not global
    {4'd1,  2'b00, 11'b00010001000, 5'b10000}, // R1 PCI read hit
    {4'd1,  2'b00, 11'b11010001000, 5'b10000}, // R1 PCI burst write
    {4'd8,  2'b00, 11'b00110001100, 5'b00000}, // R8 retried read hit
    {4'd8,  2'b00, 11'b10101001100, 5'b00000}, // R8 retried burst read miss dirty
    {4'd9,  2'b00, 11'b10101011000, 5'b00000}, // R9 inhibited burst read miss dirty
    {4'd9,  2'b00, 11'b00110011000, 5'b01000}, // R9 inhibited read hit
    {4'd9,  2'b00, 11'b11110011000, 5'b00000}, // R9 inhibited burst write hit
    {4'd9,  2'b00, 11'b01110011001, 5'b00000}, // R9 inhibited single write hit
    {4'd8,  2'b11, 11'b01111001100, 5'b00000}, // R8 retried snoop write hit dirty
    {4'd6,  2'b00, 11'b11110101000, 5'b00100}  // R6 burst write hit wt
  };

  task automatic check(input int req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: {vld,ign,sup,upd,inv,co} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [10:0] f);
    op_valid = v;
    cls = c;
    {burst, write, sys_mem, hit, dirty, wt, ci, gbl, artry, sdis, pu} = f;
  endtask

  function automatic logic [5:0] outs();
    return {resp_valid, ign, sup, upd, inv, co};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    drive(1'b1, 2'b00, 11'b10101001000);
    repeat (3) @(negedge clk);
    check(11, outs(), 6'b000000); // R11 held in reset despite an operation
    drive(1'b0, 2'b00, 11'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(11, outs(), 6'b000000); // R11 idle after reset

    for (int k = 0; k < NV; k++) begin
      drive(1'b1, VECS[k][17:16], VECS[k][15:5]);
      @(negedge clk);
      check(int'(VECS[k][21:18]), outs(), {1'b1, VECS[k][4:0]});
    end

    // R11: idle cycle following a busy one clears all flags
    drive(1'b1, 2'b00, 11'b10101001000);
    @(negedge clk);
    check(5, outs(), 6'b100101);
    drive(1'b0, 2'b00, 11'b10101001000);
    @(negedge clk);
    check(11, outs(), 6'b000000);

    // R1: PCI space wins over retry and snoop inputs
    drive(1'b1, 2'b11, 11'b01011001100);
    @(negedge clk);
    check(1, outs(), 6'b110000);

    // R11: asynchronous reset clears flags between edges
    drive(1'b1, 2'b11, 11'b01111001000);
    @(negedge clk);
    check(4, outs(), 6'b101010);
    #1 rst_ni = 1'b0;
    #1 check(11, outs(), 6'b000000);
    drive(1'b0, 2'b00, 11'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(11, outs(), 6'b000000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule